// File: doc/BRIEF.md
# Prescaled PWM timer channel

One PWM output channel. A 24-bit up-counter steps on a tick taken from its own counter clock through a prescaler that divides by 1, 16, 256 or 2048. Software sets a period and a duty value in counts. Each output period starts with the active phase, which lasts `duty` counts, and the inactive phase fills the rest of the `period` counts. A polarity bit sets which logic level is active. Duty values from zero up to the period and beyond give everything from a flat inactive output to a flat active output, with no stray pulse at either end.

The registers sit on a small single-cycle register bus in a clock domain of their own, which is asynchronous to the counter clock. Either clock may be the faster one. Software writes go into shadow registers. Each snapshot of the whole shadow set crosses to the counter domain as a single unit over a toggle request/acknowledge handshake. The counter adopts a new shape only when it clears at the end of a period. The output's rising edges, its falling edges and the counter clears cross back as toggles through two-flop synchronizers. Each one sets a sticky status bit, which can drive a level interrupt once its source is enabled.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset, `pwm_out` and `irq` are low, and every register reads back zero.
- R2: With run set, prescale 0, PERIOD = P (P ≥ 1) and DUTY = D (0 < D < P), `pwm_out` repeats every P counter-clock cycles. Each period opens with an active phase of D cycles.
- R3: DUTY = 0 holds the output at its inactive level. DUTY ≥ PERIOD holds it at its active level. Neither produces a transition while running.
- R4: CTRL bits [3:2] select the tick ratio: 0 → 1, 1 → 16, 2 → 256, 3 → 2048 counter-clock cycles per count. A period then lasts P·ratio cycles, of which D·ratio are active.
- R5: CTRL bit 1 is the polarity. At 0 the active level is high. At 1 the active level is low, so each period starts low and the idle level is high.
- R6: A new PERIOD or DUTY takes effect only when the counter clears. Every period that appears is therefore a complete old-shape or a complete new-shape period.
- R7: CTRL bit 0 is run. Clearing it drives `pwm_out` to the inactive level and returns the count to zero. Setting it again starts with a full first period.
- R8: Register STAT (address 4) holds sticky bits: bit 0 = output rising edge, bit 1 = output falling edge, bit 2 = counter clear. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some STAT bit is set whose enable bit is also set in register IEN (address 3, same bit order).
- R10: CTRL (address 0), PERIOD (address 1), DUTY (address 2) and IEN read back what was written. Bits that are not implemented read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| reg_we | input | 1 | Write strobe, one bus cycle per write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| cnt_clk | input | 1 | Counter clock |
| cnt_rst_n | input | 1 | Synchronous active-low reset, counter domain |
| pwm_out | output | 1 | PWM waveform, registered |
| irq | output | 1 | Level interrupt, registered in the bus domain |

## Verification
The bench uses the default parameters: a 24-bit counter and prescale shifts of 0, 4, 8 and 11. It programs periods of only 2 to 10 counts, so even the divide-by-2048 setting finishes a few periods within several thousand counter cycles. The counter clock runs faster than the bus clock and at an unrelated ratio, so handshake snapshots land at arbitrary points within a period. This exposes the clear-boundary rule when PERIOD is rewritten while the channel runs.

// File: rtl/pwm_ch_pkg.sv
// Shared definitions for the PWM timer channel: register addresses,
// control field positions, event indices and the prescale encoding.
package pwm_ch_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] A_PERIOD = 3'd1;
    localparam logic [REG_AW-1:0] A_DUTY   = 3'd2;
    localparam logic [REG_AW-1:0] A_IEN    = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT   = 3'd4;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_POL = 1;
    localparam int CTRL_DIV = 2;

    localparam int EV_RISE = 0;
    localparam int EV_FALL = 1;
    localparam int EV_CLR  = 2;
    localparam int EV_N    = 3;

    typedef enum logic [1:0] {
        DIV_1    = 2'd0,
        DIV_16   = 2'd1,
        DIV_256  = 2'd2,
        DIV_2048 = 2'd3
    } div_sel_e;
endpackage

// File: rtl/pwm_sync.sv
// Two-flop synchronizer for W independent quasi-static or toggle bits.
// Assumes each bit changes at most once per a few destination cycles.
module pwm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two destination-clock stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pwm_ch_regs.sv
// Bus-domain register file. Holds the shadow configuration and launches
// snapshots of it to the counter domain over a toggle request/acknowledge
// handshake. Also turns the synchronized event toggles into sticky W1C
// status bits and a registered interrupt.
// Assumes writes are one-cycle strobes and DATA_W > CNT_W.
module pwm_ch_regs
    import pwm_ch_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [EV_N-1:0]   ev_tgl_async,
    input  logic              ack_tgl_async,
    output logic              req_tgl,
    output logic              x_run,
    output logic              x_pol,
    output div_sel_e          x_div,
    output logic [CNT_W-1:0]  x_per,
    output logic [CNT_W-1:0]  x_duty,
    output logic              irq
);
    logic             run_q, pol_q;
    div_sel_e         div_q;
    logic [CNT_W-1:0] per_q, duty_q;
    logic [EV_N-1:0]  en_q, stat_q, ev_s, ev_d_q, ev_pulse, w1c;
    logic             pend_q, ack_s, busy, launch, cfg_wr;
    logic             unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CNT_W];

    pwm_sync #(.W(1))    u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_tgl_async), .q(ack_s));
    pwm_sync #(.W(EV_N)) u_ev_sync  (.clk(clk), .rst_n(rst_n), .d(ev_tgl_async),  .q(ev_s));

    assign busy     = req_tgl ^ ack_s;
    assign launch   = pend_q & ~busy;
    assign cfg_wr   = we && (addr == A_CTRL || addr == A_PERIOD || addr == A_DUTY);
    assign w1c      = (we && addr == A_STAT) ? wdata[EV_N-1:0] : '0;
    assign ev_pulse = ev_s ^ ev_d_q;

    // Shadow registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pol_q  <= 1'b0;
            div_q  <= DIV_1;
            per_q  <= '0;
            duty_q <= '0;
            en_q   <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    run_q <= wdata[CTRL_RUN];
                    pol_q <= wdata[CTRL_POL];
                    div_q <= div_sel_e'(wdata[CTRL_DIV+:2]);
                end
                A_PERIOD: per_q  <= wdata[CNT_W-1:0];
                A_DUTY:   duty_q <= wdata[CNT_W-1:0];
                A_IEN:    en_q   <= wdata[EV_N-1:0];
                default:  ;
            endcase
        end
    end

    // Snapshot launch: one transfer in flight, later writes coalesce.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            req_tgl <= 1'b0;
            x_run   <= 1'b0;
            x_pol   <= 1'b0;
            x_div   <= DIV_1;
            x_per   <= '0;
            x_duty  <= '0;
        end else begin
            pend_q <= cfg_wr | (pend_q & ~launch);
            if (launch) begin
                x_run   <= run_q;
                x_pol   <= pol_q;
                x_div   <= div_q;
                x_per   <= per_q;
                x_duty  <= duty_q;
                req_tgl <= ~req_tgl;
            end
        end
    end

    // Sticky status (set wins over clear) and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_d_q <= '0;
            stat_q <= '0;
            irq    <= 1'b0;
        end else begin
            ev_d_q <= ev_s;
            stat_q <= (stat_q & ~w1c) | ev_pulse;
            irq    <= |(stat_q & en_q);
        end
    end

    // Read mux; bits that are not implemented read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_RUN]     = run_q;
                rdata[CTRL_POL]     = pol_q;
                rdata[CTRL_DIV+:2]  = div_q;
            end
            A_PERIOD: rdata[CNT_W-1:0] = per_q;
            A_DUTY:   rdata[CNT_W-1:0] = duty_q;
            A_IEN:    rdata[EV_N-1:0]  = en_q;
            A_STAT:   rdata[EV_N-1:0]  = stat_q;
            default:  ;
        endcase
    end

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_STAT && wdata[EV_RISE] && !ev_pulse[EV_RISE]) |=> !stat_q[EV_RISE]);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|en_q));

    assert_period_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_PERIOD) |=> (per_q == $past(wdata[CNT_W-1:0])));

    assert_xfer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(x_per) && $stable(x_duty) && $stable(x_run) && $stable(x_pol)));
endmodule

// File: rtl/pwm_ch_core.sv
// Counter-domain engine: it captures configuration snapshots, runs the
// prescaler and the 24-bit counter, makes the registered PWM output and
// emits event toggles. A new shape is adopted only at a counter clear,
// and at once while stopped.
// Assumes the x_* inputs hold still from a request toggle until its
// acknowledge, and that SH2048 is the largest shift.
module pwm_ch_core
    import pwm_ch_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int SH1    = 0,
    parameter int SH16   = 4,
    parameter int SH256  = 8,
    parameter int SH2048 = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl_async,
    input  logic             x_run,
    input  logic             x_pol,
    input  div_sel_e         x_div,
    input  logic [CNT_W-1:0] x_per,
    input  logic [CNT_W-1:0] x_duty,
    output logic             ack_tgl,
    output logic [EV_N-1:0]  ev_tgl,
    output logic             pwm_out
);
    localparam int PRE_W = (SH2048 > 0) ? SH2048 : 1;
    localparam int CW1   = CNT_W + 1;
    localparam logic [PRE_W-1:0] LIM1    = PRE_W'((64'd1 << SH1) - 64'd1);
    localparam logic [PRE_W-1:0] LIM16   = PRE_W'((64'd1 << SH16) - 64'd1);
    localparam logic [PRE_W-1:0] LIM256  = PRE_W'((64'd1 << SH256) - 64'd1);
    localparam logic [PRE_W-1:0] LIM2048 = PRE_W'((64'd1 << SH2048) - 64'd1);

    logic             req_s, req_d_q, take;
    logic             stg_run, stg_pol;
    div_sel_e         stg_div;
    logic [CNT_W-1:0] stg_per, stg_duty;
    logic             run_act, pol_act;
    div_sel_e         div_act;
    logic [CNT_W-1:0] per_act, duty_act, cnt_q;
    logic [PRE_W-1:0] presc_q, lim;
    logic             tick, wrap, clr_evt, pwm_q, pwm_d_q, rise, fall;

    pwm_sync #(.W(1)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_tgl_async), .q(req_s));

    assign take = req_s ^ req_d_q;

    // Capture a snapshot on each request toggle and acknowledge it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d_q  <= 1'b0;
            ack_tgl  <= 1'b0;
            stg_run  <= 1'b0;
            stg_pol  <= 1'b0;
            stg_div  <= DIV_1;
            stg_per  <= '0;
            stg_duty <= '0;
        end else begin
            req_d_q <= req_s;
            if (take) begin
                stg_run  <= x_run;
                stg_pol  <= x_pol;
                stg_div  <= x_div;
                stg_per  <= x_per;
                stg_duty <= x_duty;
                ack_tgl  <= req_s;
            end
        end
    end

    // Tick limit for the active prescale selection.
    always_comb begin
        case (div_act)
            DIV_1:   lim = LIM1;
            DIV_16:  lim = LIM16;
            DIV_256: lim = LIM256;
            default: lim = LIM2048;
        endcase
    end

    assign tick    = (presc_q == lim);
    assign wrap    = (CW1'(cnt_q) + CW1'(1)) >= CW1'(per_act);
    assign clr_evt = run_act & tick & wrap;

    // Prescaler: restarts while stopped and after every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_act || tick) presc_q <= '0;
        else                            presc_q <= presc_q + PRE_W'(1);
    end

    // Run state, active shape (loaded while stopped or at a clear) and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_act  <= 1'b0;
            pol_act  <= 1'b0;
            div_act  <= DIV_1;
            per_act  <= '0;
            duty_act <= '0;
            cnt_q    <= '0;
        end else begin
            run_act <= stg_run;
            if (!run_act || clr_evt) begin
                pol_act  <= stg_pol;
                div_act  <= stg_div;
                per_act  <= stg_per;
                duty_act <= stg_duty;
                cnt_q    <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Registered, glitch-free output; idle level is the inactive one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q   <= 1'b0;
            pwm_d_q <= 1'b0;
        end else begin
            pwm_q   <= run_act ? ((cnt_q < duty_act) ^ pol_act) : pol_act;
            pwm_d_q <= pwm_q;
        end
    end

    assign rise = pwm_q & ~pwm_d_q;
    assign fall = ~pwm_q & pwm_d_q;

    // Event toggles toward the bus domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_tgl <= '0;
        end else begin
            ev_tgl[EV_RISE] <= ev_tgl[EV_RISE] ^ rise;
            ev_tgl[EV_FALL] <= ev_tgl[EV_FALL] ^ fall;
            ev_tgl[EV_CLR]  <= ev_tgl[EV_CLR] ^ clr_evt;
        end
    end

    assign pwm_out = pwm_q;

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_act |-> (cnt_q == '0 || cnt_q < per_act));

    assert_duty_zero_flat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && duty_act == '0) |=> (pwm_q == $past(pol_act)));

    assert_duty_full_flat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && per_act != '0 && duty_act >= per_act) |=> (pwm_q == !$past(pol_act)));

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && div_act != DIV_1 && tick) |=> (!tick || div_act == DIV_1));

    assert_shape_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && !clr_evt) |=> ($stable(per_act) && $stable(duty_act)));

    assert_idle_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_act |=> (pwm_q == $past(pol_act)));
endmodule

// File: rtl/pwm_timer_ch.sv
// Top of the PWM timer channel: the bus-domain register file and the
// counter-domain engine, joined only by the handshake and event toggles.
// Assumes the two clocks are unrelated and each domain has its own reset.
module pwm_timer_ch
    import pwm_ch_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int DATA_W     = 32,
    parameter int SH_DIV1    = 0,
    parameter int SH_DIV16   = 4,
    parameter int SH_DIV256  = 8,
    parameter int SH_DIV2048 = 11
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    output logic              pwm_out,
    output logic              irq
);
    logic             req_tgl, ack_tgl, x_run, x_pol;
    div_sel_e         x_div;
    logic [CNT_W-1:0] x_per, x_duty;
    logic [EV_N-1:0]  ev_tgl;

    pwm_ch_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ev_tgl_async(ev_tgl),
        .ack_tgl_async(ack_tgl), .req_tgl(req_tgl), .x_run(x_run),
        .x_pol(x_pol), .x_div(x_div), .x_per(x_per), .x_duty(x_duty), .irq(irq)
    );

    pwm_ch_core #(
        .CNT_W(CNT_W), .SH1(SH_DIV1), .SH16(SH_DIV16),
        .SH256(SH_DIV256), .SH2048(SH_DIV2048)
    ) u_core (
        .clk(cnt_clk), .rst_n(cnt_rst_n), .req_tgl_async(req_tgl),
        .x_run(x_run), .x_pol(x_pol), .x_div(x_div), .x_per(x_per),
        .x_duty(x_duty), .ack_tgl(ack_tgl), .ev_tgl(ev_tgl), .pwm_out(pwm_out)
    );
endmodule

// File: tb/pwm_timer_ch_bench.sv
// Scoreboard bench: the driver pushes expected period shapes, and a monitor
// in the counter domain measures each period and pops and compares.
module pwm_timer_ch_bench;
    import pwm_ch_pkg::*;

    localparam int BUS_CLK_PERIOD = 10;
    localparam int CNT_CLK_PERIOD = 6;
    localparam int WATCHDOG_CYC   = 150000;

    typedef struct {
        string req;
        int    hi;
        int    tot;
        int    alt_hi;
        int    alt_tot;
    } wave_t;

    logic        bus_clk = 1'b0, cnt_clk = 1'b0;
    logic        bus_rst_n = 1'b0, cnt_rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out, irq;
    logic        pol_exp = 1'b0;
    wave_t       sb_q[$];
    int          n_run = 0, n_fail = 0;

    always #(BUS_CLK_PERIOD / 2) bus_clk = ~bus_clk;
    always #(CNT_CLK_PERIOD / 2) cnt_clk = ~cnt_clk;

    pwm_timer_ch u_pwm_timer_ch (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_bus(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Stop, reprogram, restart; waits so that each step reaches the counter.
    task automatic run_cfg(input logic p, input logic [1:0] dv, input int per, input int dt);
        bus_wr(A_CTRL, {28'd0, dv, p, 1'b0});
        wait_bus(12);
        bus_wr(A_PERIOD, per);
        bus_wr(A_DUTY, dt);
        pol_exp = p;
        bus_wr(A_CTRL, {28'd0, dv, p, 1'b1});
        wait_bus(12);
    endtask

    task automatic push_wave(input string req, input int hi, input int tot,
                             input int ahi, input int atot, input int n);
        for (int i = 0; i < n; i++) begin
            wave_t it;
            it.req = req; it.hi = hi; it.tot = tot; it.alt_hi = ahi; it.alt_tot = atot;
            sb_q.push_back(it);
        end
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        wait_bus(2);
    endtask

    task automatic check_flat(input string req, input logic lvl, input int n);
        int bad = 0;
        logic seen = lvl;
        for (int i = 0; i < n; i++) begin
            @(negedge cnt_clk);
            if (pwm_out !== lvl) begin bad++; seen = pwm_out; end
        end
        n_run++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: actual level %0b in %0d cycles expected %0b", req, seen, bad, lvl);
        end
    endtask

    // Monitor: sync to an active-going edge, then measure queued periods.
    initial begin : monitor
        logic a, pa;
        int hi, lo;
        forever begin
            wait (sb_q.size() > 0);
            a = 1'b1;
            do begin
                @(negedge cnt_clk);
                pa = a;
                a = pwm_out ^ pol_exp;
            end while (!(a && !pa));
            while (sb_q.size() > 0) begin
                wave_t it;
                hi = 1; lo = 0;
                @(negedge cnt_clk); a = pwm_out ^ pol_exp;
                while (a)  begin hi++; @(negedge cnt_clk); a = pwm_out ^ pol_exp; end
                while (!a) begin lo++; @(negedge cnt_clk); a = pwm_out ^ pol_exp; end
                it = sb_q.pop_front();
                n_run++;
                if (!((hi == it.hi && hi + lo == it.tot) ||
                      (hi == it.alt_hi && hi + lo == it.alt_tot))) begin
                    n_fail++;
                    $display("FAIL %s: actual high %0d period %0d expected high %0d period %0d",
                             it.req, hi, hi + lo, it.hi, it.tot);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG_CYC) @(posedge bus_clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual still running expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : driver
        logic [31:0] rd;
        wait_bus(5);
        bus_rst_n = 1'b1; cnt_rst_n = 1'b1;
        wait_bus(2);

        // R1: reset state
        chk("R1 pwm_out", {31'd0, pwm_out}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 5; a++) begin
            bus_rd(3'(a), rd);
            chk("R1 register", rd, 32'd0);
        end

        // R10: readback, unimplemented bits zero
        bus_wr(A_PERIOD, 32'hFFAB_CDEF); bus_rd(A_PERIOD, rd); chk("R10 period", rd, 32'h00AB_CDEF);
        bus_wr(A_DUTY, 32'h0012_3456);   bus_rd(A_DUTY, rd);   chk("R10 duty", rd, 32'h0012_3456);
        bus_wr(A_IEN, 32'h0000_00FD);    bus_rd(A_IEN, rd);    chk("R10 ien", rd, 32'd5);
        bus_wr(A_CTRL, 32'h0000_00FE);   bus_rd(A_CTRL, rd);   chk("R10 ctrl", rd, 32'hE);
        bus_wr(A_CTRL, 32'd0);
        wait_bus(12);

        // R2: plain waveforms at divide-by-1
        run_cfg(1'b0, 2'd0, 5, 2); push_wave("R2 p5d2", 2, 5, 2, 5, 3); drain();
        run_cfg(1'b0, 2'd0, 8, 7); push_wave("R2 p8d7", 7, 8, 7, 8, 3); drain();
        run_cfg(1'b0, 2'd0, 2, 1); push_wave("R2 p2d1", 1, 2, 1, 2, 3); drain();

        // R3: flat extremes
        run_cfg(1'b0, 2'd0, 4, 0); wait_bus(10); check_flat("R3 duty0", 1'b0, 60);
        run_cfg(1'b0, 2'd0, 4, 9); wait_bus(10); check_flat("R3 duty>=period", 1'b1, 60);

        // R4: prescale ratios
        run_cfg(1'b0, 2'd1, 3, 1); push_wave("R4 div16", 16, 48, 16, 48, 2); drain();
        run_cfg(1'b0, 2'd2, 2, 1); push_wave("R4 div256", 256, 512, 256, 512, 2); drain();
        run_cfg(1'b0, 2'd3, 2, 1); push_wave("R4 div2048", 2048, 4096, 2048, 4096, 2); drain();

        // R5: inverted polarity, active phase low first
        run_cfg(1'b1, 2'd0, 5, 2); push_wave("R5 inverted", 2, 5, 2, 5, 2); drain();

        // R7: stop drives the inactive level; restart gives a full first period
        bus_wr(A_CTRL, 32'h2); wait_bus(12);
        check_flat("R7 idle high", 1'b1, 40);
        push_wave("R7 first period", 2, 5, 2, 5, 1);
        bus_wr(A_CTRL, 32'h3);
        drain();
        bus_wr(A_CTRL, 32'h0); wait_bus(12); pol_exp = 1'b0;
        check_flat("R7 idle low", 1'b0, 40);

        // R6: period rewritten while running; only whole periods appear
        run_cfg(1'b0, 2'd0, 6, 2); wait_bus(5);
        push_wave("R6 transition", 2, 6, 2, 10, 6);
        bus_wr(A_PERIOD, 32'd10);
        drain();
        push_wave("R6 new shape", 2, 10, 2, 10, 2); drain();

        // R8 / R9: sticky status, write-1-to-clear, enable gating
        bus_wr(A_CTRL, 32'h0); wait_bus(12);
        bus_rd(A_STAT, rd); chk("R8 all events seen", rd, 32'd7);
        bus_wr(A_STAT, 32'd0); bus_rd(A_STAT, rd); chk("R8 write 0 no effect", rd, 32'd7);
        bus_wr(A_IEN, 32'd0); wait_bus(3); chk("R9 disabled", {31'd0, irq}, 32'd0);
        bus_wr(A_IEN, 32'd4); wait_bus(3); chk("R9 clear enabled", {31'd0, irq}, 32'd1);
        bus_wr(A_STAT, 32'd1); bus_rd(A_STAT, rd); chk("R8 clear rise", rd, 32'd6);
        bus_wr(A_STAT, 32'd4); wait_bus(3); chk("R9 source cleared", {31'd0, irq}, 32'd0);
        bus_rd(A_STAT, rd); chk("R8 fall left", rd, 32'd2);
        bus_wr(A_STAT, 32'd2); bus_rd(A_STAT, rd); chk("R8 all cleared", rd, 32'd0);

        // R8: duty 0 produces only counter-clear events
        run_cfg(1'b0, 2'd0, 4, 0); wait_bus(20);
        bus_wr(A_CTRL, 32'h0); wait_bus(12);
        bus_rd(A_STAT, rd); chk("R8 clear only", rd, 32'd4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule